// File: doc/BRIEF.md
# Target Read Path with Wait-Timeout Disconnect

This block serves read transactions that an initiator on the bus side aims at add-on logic. While a read transaction is open it raises a request status toward the add-on. The add-on answers by pushing 32-bit words into an eight-entry read FIFO. The target-ready strobe toward the initiator follows FIFO occupancy alone: it is high in any transfer cycle in which the FIFO holds a word. If the initiator waits too long on an empty FIFO, the block ends the burst with a disconnect so that the bus is released rather than stalled. With prefetch enabled, the block keeps requesting until the FIFO is full, without waiting for demand, and it flags that activity as a burst. Words still in the FIFO when a transaction ends are discarded.

Both data paths follow valid/ready rules. On the add-on side, a word moves when `ao_wvalid` and `ao_wready` are high on the same clock edge. The add-on must hold `ao_wdata` and `ao_wvalid` while `ao_wready` is low. On the initiator side, `tgt_ready` acts as the valid strobe and `rq_take` as the ready. The head word stays on `tgt_data` until a cycle in which both are high. The active-low add-on handshake `ao_rdy_n` has two meanings, selected by `cfg_active`. In passive mode a low level marks the completion of each add-on transfer. In active mode a low level inserts a wait state. `cfg_active`, `cfg_prefetch` and `rq_burst` are held stable for the whole of a transaction.

Top module: `tgt_read_path`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `tgt_ready`, `tgt_stop`, `ao_attn`, `ao_burst` and `ao_wready` are all low.
- R2: When `rq_frame` rises while the block is idle, the transfer state begins on the next clock edge. With prefetch off, `rq_take` high and the FIFO empty, `ao_attn` is then high.
- R3: `tgt_ready` is high only in the transfer state, only while the FIFO holds a word, and never together with `tgt_stop`. It first rises in the cycle after the clock edge that accepts an add-on word. `tgt_data` always shows the oldest stored word.
- R4: Each clock edge on which `tgt_ready` and `rq_take` are both high removes exactly one word. While words remain, `tgt_ready` stays high on consecutive cycles and the words come out in the order they were written. While `rq_take` is low, the head word is held.
- R5: `tgt_stop` rises after WAIT_LIMIT (8) consecutive transfer-state cycles in which `rq_frame` and `rq_take` are high and the FIFO is empty. It stays high until `rq_frame` falls. While `tgt_stop` is high, `tgt_ready` and `ao_attn` are low.
- R6: Any cycle in which the FIFO holds a word restarts the wait count from zero.
- R7: With prefetch off, `ao_attn` is high only while the FIFO is empty and `rq_take` is high, so the add-on supplies one word at a time.
- R8: With prefetch on, `ao_attn` is high in the transfer state whenever the FIFO is not full, whatever the level of `rq_take`. `ao_burst` is high in the transfer state when `rq_burst` or prefetch is set, and low otherwise.
- R9: The FIFO holds 8 words. When it is full, `ao_attn` and `ao_wready` are low and no further word is accepted.
- R10: When `rq_frame` falls, all stored words are discarded. The next transaction starts with `tgt_ready` low and delivers only newly written words.
- R11: In passive mode (`cfg_active` = 0), `ao_wready` is high only while `ao_attn` is high and `ao_rdy_n` is low. A word offered while `ao_rdy_n` is high is ignored.
- R12: In active mode (`cfg_active` = 1), `ao_rdy_n` low forces `ao_wready` low for that cycle (a wait state). `ao_rdy_n` high lets `ao_wready` follow `ao_attn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_active | input | 1 | 1 = active add-on handshake, 0 = passive |
| cfg_prefetch | input | 1 | 1 = fill the FIFO ahead of demand |
| rq_frame | input | 1 | Initiator read transaction open |
| rq_burst | input | 1 | Initiator intends a multi-phase burst |
| rq_take | input | 1 | Initiator ready to accept a data phase |
| tgt_ready | output | 1 | Target ready: a read word is presented |
| tgt_data | output | 32 | Read word toward the initiator |
| tgt_stop | output | 1 | Disconnect after a wait timeout |
| ao_attn | output | 1 | Request for data toward the add-on |
| ao_burst | output | 1 | Current access is a burst or a prefetch |
| ao_rdy_n | input | 1 | Active-low add-on handshake (completion or wait, by mode) |
| ao_wvalid | input | 1 | Add-on offers a word |
| ao_wdata | input | 32 | Word from the add-on |
| ao_wready | output | 1 | Word accepted on this edge if valid |

## Verification
On every cycle, the assertions check that the FIFO never overflows or underflows, that a disconnect only ever follows a completed run of the wait timer, and that the FIFO is empty after every transaction ends. The bench scenarios cover what a single-cycle property cannot capture. These include the exact cycle in which the disconnect appears after eight empty waits, and the restart of that count when one word arrives partway through a run. The scenarios also check word order across a full eight-word prefetch, the discarding of leftover words that only shows in the next transaction, and the two meanings of the add-on handshake in passive and active mode.

// File: rtl/tgt_rd_pkg.sv
package tgt_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HALT = 2'd2
  } trp_state_t;
endpackage

// File: rtl/trp_fifo.sv
module trp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CAP);
  assign do_wr   = wr_en && !full && !flush;
  assign do_rd   = rd_en && !empty && !flush;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full)
    else $error("write offered to a full read FIFO");

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty)
    else $error("data phase taken from an empty read FIFO");
endmodule

// File: rtl/trp_wait_timer.sv
module trp_wait_timer #(
  parameter int WAIT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (WAIT_LIMIT > 2) ? $clog2(WAIT_LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(WAIT_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assert_expire_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(run))
    else $error("wait timer expired without a preceding wait run");
endmodule

// File: rtl/trp_ctrl.sv
module trp_ctrl
  import tgt_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic take,
  input  logic prefetch,
  input  logic burst_req,
  input  logic fifo_empty,
  input  logic fifo_full,
  input  logic expire,
  output logic xfer,
  output logic halt,
  output logic waiting,
  output logic attn,
  output logic burst,
  output logic flush
);
  trp_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (frame) st_nx = ST_XFER;
      ST_XFER: begin
        if (!frame)      st_nx = ST_IDLE;
        else if (expire) st_nx = ST_HALT;
      end
      ST_HALT: if (!frame) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign xfer    = (st == ST_XFER);
  assign halt    = (st == ST_HALT);
  assign flush   = (st != ST_IDLE) && !frame;
  assign waiting = xfer && frame && take && fifo_empty;
  assign attn    = xfer && frame && (prefetch ? !fifo_full : (take && fifo_empty));
  assign burst   = xfer && (burst_req || prefetch);

  assert_stop_from_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(expire))
    else $error("disconnect entered without a wait timeout");
endmodule

// File: rtl/tgt_read_path.sv
module tgt_read_path #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int WAIT_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_active,
  input  logic              cfg_prefetch,
  input  logic              rq_frame,
  input  logic              rq_burst,
  input  logic              rq_take,
  output logic              tgt_ready,
  output logic [DATA_W-1:0] tgt_data,
  output logic              tgt_stop,
  output logic              ao_attn,
  output logic              ao_burst,
  input  logic              ao_rdy_n,
  input  logic              ao_wvalid,
  input  logic [DATA_W-1:0] ao_wdata,
  output logic              ao_wready
);
  logic fifo_empty, fifo_full, fifo_flush, fifo_wr, fifo_rd;
  logic wait_run, wait_expire, in_xfer, in_halt, attn;
  logic hs_ok;

  // Handshake qualifier: passive needs the completion mark, active treats low as wait.
  assign hs_ok     = cfg_active ? ao_rdy_n : !ao_rdy_n;
  assign ao_attn   = attn;
  assign ao_wready = attn && hs_ok;
  assign fifo_wr   = ao_wvalid && ao_wready;
  assign tgt_ready = in_xfer && !fifo_empty;
  assign fifo_rd   = tgt_ready && rq_take;
  assign tgt_stop  = in_halt;

  trp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame     (rq_frame),
    .take      (rq_take),
    .prefetch  (cfg_prefetch),
    .burst_req (rq_burst),
    .fifo_empty(fifo_empty),
    .fifo_full (fifo_full),
    .expire    (wait_expire),
    .xfer      (in_xfer),
    .halt      (in_halt),
    .waiting   (wait_run),
    .attn      (attn),
    .burst     (ao_burst),
    .flush     (fifo_flush)
  );

  trp_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (wait_run),
    .expire(wait_expire)
  );

  trp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (fifo_flush),
    .wr_en  (fifo_wr),
    .wr_data(ao_wdata),
    .rd_en  (fifo_rd),
    .rd_data(tgt_data),
    .empty  (fifo_empty),
    .full   (fifo_full)
  );

  assert_flush_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_xfer || in_halt) && !rq_frame) |=> fifo_empty)
    else $error("read FIFO not emptied at transaction end");
endmodule

// File: tb/sim_tgt_read_path.sv
`timescale 1ns/1ps
module sim_tgt_read_path;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_active, cfg_prefetch;
  logic        rq_frame, rq_burst, rq_take;
  logic        tgt_ready, tgt_stop, ao_attn, ao_burst, ao_wready;
  logic [31:0] tgt_data;
  logic        ao_rdy_n, ao_wvalid;
  logic [31:0] ao_wdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tgt_read_path u0 (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_prefetch(cfg_prefetch),
    .rq_frame(rq_frame), .rq_burst(rq_burst), .rq_take(rq_take),
    .tgt_ready(tgt_ready), .tgt_data(tgt_data), .tgt_stop(tgt_stop),
    .ao_attn(ao_attn), .ao_burst(ao_burst), .ao_rdy_n(ao_rdy_n),
    .ao_wvalid(ao_wvalid), .ao_wdata(ao_wdata), .ao_wready(ao_wready)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_bus();
    rq_frame = 0; rq_take = 0; rq_burst = 0; ao_wvalid = 0; ao_rdy_n = 1;
    step(); step();
  endtask

  task automatic t_reset();
    rst_n = 0;
    step(); #1;
    chk("R1", "tgt_ready in reset", 32'(tgt_ready), 0);
    chk("R1", "tgt_stop in reset",  32'(tgt_stop), 0);
    chk("R1", "ao_attn in reset",   32'(ao_attn), 0);
    chk("R1", "ao_burst in reset",  32'(ao_burst), 0);
    chk("R1", "ao_wready in reset", 32'(ao_wready), 0);
    step(); rst_n = 1;
    step(); #1;
    chk("R1", "tgt_ready after reset", 32'(tgt_ready), 0);
    chk("R1", "ao_attn after reset", 32'(ao_attn), 0);
  endtask

  // Passive mode, no prefetch, single word.
  task automatic t_single();
    cfg_active = 0; cfg_prefetch = 0;
    step(); rq_frame = 1; rq_take = 1;
    step(); #1;
    chk("R2", "ao_attn after frame", 32'(ao_attn), 1);
    chk("R3", "tgt_ready with empty FIFO", 32'(tgt_ready), 0);
    ao_wvalid = 1; ao_wdata = 32'hA5A5_0001; ao_rdy_n = 1; #1;
    chk("R11", "ao_wready without completion mark", 32'(ao_wready), 0);
    step(); #1;
    chk("R11", "word ignored without completion mark", 32'(tgt_ready), 0);
    ao_rdy_n = 0; #1;
    chk("R11", "ao_wready with completion mark", 32'(ao_wready), 1);
    step(); ao_wvalid = 0; ao_rdy_n = 1; #1;
    chk("R3", "tgt_ready after write", 32'(tgt_ready), 1);
    chk("R3", "tgt_data", tgt_data, 32'hA5A5_0001);
    chk("R7", "ao_attn with word held", 32'(ao_attn), 0);
    step(); #1;
    chk("R4", "tgt_ready after word taken", 32'(tgt_ready), 0);
    chk("R7", "ao_attn after FIFO drained", 32'(ao_attn), 1);
    idle_bus();
  endtask

  // Active mode, prefetch, fill to full then drain.
  task automatic t_burst();
    cfg_active = 1; cfg_prefetch = 1;
    step(); rq_frame = 1; rq_burst = 1; rq_take = 0; ao_rdy_n = 1;
    step(); #1;
    chk("R8", "ao_burst during prefetch", 32'(ao_burst), 1);
    chk("R8", "ao_attn without demand", 32'(ao_attn), 1);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        ao_wvalid = 1; ao_wdata = 32'hDEAD_0000; ao_rdy_n = 0; #1;
        chk("R12", "ao_wready during wait state", 32'(ao_wready), 0);
        step(); ao_rdy_n = 1;
      end
      ao_wvalid = 1; ao_wdata = 32'hC000_0000 + 32'(i); #1;
      chk("R12", "ao_wready without wait", 32'(ao_wready), 1);
      step();
    end
    ao_wvalid = 1; ao_wdata = 32'hBAD0_BAD0; #1;
    chk("R9", "ao_wready when full", 32'(ao_wready), 0);
    chk("R9", "ao_attn when full", 32'(ao_attn), 0);
    chk("R4", "head held while take low", tgt_data, 32'hC000_0000);
    step(); ao_wvalid = 0; rq_take = 1;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R4", "tgt_ready back to back", 32'(tgt_ready), 1);
      chk("R4", "word order", tgt_data, 32'hC000_0000 + 32'(i));
      step();
    end
    #1;
    chk("R4", "tgt_ready after drain", 32'(tgt_ready), 0);
    idle_bus();
  endtask

  // Leftover prefetched words are discarded at end of transaction.
  task automatic t_flush();
    cfg_active = 1; cfg_prefetch = 1;
    step(); rq_frame = 1; rq_take = 0; ao_rdy_n = 1;
    step();
    for (int i = 0; i < 3; i++) begin
      ao_wvalid = 1; ao_wdata = 32'hE000_0000 + 32'(i);
      step();
    end
    ao_wvalid = 0; rq_take = 1; #1;
    chk("R4", "first prefetched word", tgt_data, 32'hE000_0000);
    step(); rq_take = 0; rq_frame = 0;
    step();
    cfg_active = 0; cfg_prefetch = 0;
    rq_frame = 1; rq_take = 1;
    step(); #1;
    chk("R10", "tgt_ready in new transaction", 32'(tgt_ready), 0);
    chk("R8", "ao_burst without burst or prefetch", 32'(ao_burst), 0);
    ao_wvalid = 1; ao_rdy_n = 0; ao_wdata = 32'hF00D_0001;
    step(); ao_wvalid = 0; ao_rdy_n = 1; #1;
    chk("R10", "only new word delivered", tgt_data, 32'hF00D_0001);
    idle_bus();
  endtask

  // A word arriving mid-run restarts the wait count.
  task automatic t_restart();
    cfg_active = 0; cfg_prefetch = 0;
    step(); rq_frame = 1; rq_take = 1;
    for (int k = 0; k < 5; k++) step();
    ao_wvalid = 1; ao_rdy_n = 0; ao_wdata = 32'h0000_5EED; #1;
    chk("R6", "ao_wready mid-run", 32'(ao_wready), 1);
    step(); ao_wvalid = 0; ao_rdy_n = 1; #1;
    chk("R6", "word delivered mid-run", tgt_data, 32'h0000_5EED);
    for (int k = 0; k < 7; k++) begin
      step(); #1;
      chk("R6", "no disconnect after restart", 32'(tgt_stop), 0);
    end
    idle_bus();
  endtask

  // Eight empty waits lead to a disconnect.
  task automatic t_disconnect();
    cfg_active = 0; cfg_prefetch = 0;
    step(); rq_frame = 1; rq_take = 1;
    for (int k = 0; k < 8; k++) begin
      step(); #1;
      chk("R5", "no disconnect before limit", 32'(tgt_stop), 0);
    end
    step(); #1;
    chk("R5", "disconnect at limit", 32'(tgt_stop), 1);
    chk("R5", "tgt_ready low in disconnect", 32'(tgt_ready), 0);
    chk("R5", "ao_attn low in disconnect", 32'(ao_attn), 0);
    step(); #1;
    chk("R5", "disconnect held", 32'(tgt_stop), 1);
    rq_frame = 0; rq_take = 0;
    step(); #1;
    chk("R5", "disconnect released", 32'(tgt_stop), 0);
    idle_bus();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL all watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cfg_active = 0; cfg_prefetch = 0; rq_frame = 0; rq_burst = 0; rq_take = 0;
    ao_rdy_n = 1; ao_wvalid = 0; ao_wdata = '0;
    t_reset();
    t_single();
    t_burst();
    t_flush();
    t_restart();
    t_disconnect();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule